// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Order

This block produces the address for a four-beat burst into a synchronous SRAM. On a rising clock edge, an active-low strobe on either of two independent load inputs captures an external address. That address becomes the start of a burst, and the beat count returns to zero. On each later edge where the active-low advance input is low, the beat count steps by one. The two low address bits then follow the selected order, and the upper bits stay as they were loaded.

A static order-select input chooses between two orders. When it is low, the low bits add the beat count to the starting bits, modulo four. When it is high, the low bits are the starting bits XORed with the beat count. After four beats the sequence returns to its starting value. A controller that does not use bursts can load a new address on every cycle, and no idle cycles are needed.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high `rst` clears `addr_out` and `beat` to zero on the next rising edge, including in the middle of a burst.
- R2: If `strb_a_n` is low at a rising edge, `addr_out` equals the sampled `addr_in` after that edge, and `beat` is 0.
- R3: If `strb_b_n` is low at a rising edge, it has the same effect as R2. If both strobes are low together, a single load happens.
- R4: With `order_xor` = 0, `addr_out[1:0]` equals (starting low bits + `beat`) mod 4. For example, a start of 2'b10 gives 10, 11, 00, 01.
- R5: With `order_xor` = 1, `addr_out[1:0]` equals the starting low bits XOR `beat`. For example, a start of 2'b01 gives 01, 00, 11, 10.
- R6: If `adv_n` is low and both strobes are high at a rising edge, `beat` increments modulo 4. The fifth address of a burst equals its first address.
- R7: If both strobes and `adv_n` are high at a rising edge, `addr_out` and `beat` stay unchanged.
- R8: If a strobe and `adv_n` are both low at the same edge, the load wins. `beat` becomes 0 and `addr_out` takes the new address.
- R9: While no strobe is asserted, `addr_out[ADDR_W-1:2]` stays unchanged.
- R10: Loads on consecutive cycles each take effect in the edge that samples them, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strb_a_n | input | 1 | First load strobe, active low |
| strb_b_n | input | 1 | Second load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_xor | input | 1 | Order select: 0 = linear, 1 = interleaved (XOR) |
| addr_in | input | ADDR_W | External address sampled on a load |
| addr_out | output | ADDR_W | Current burst address |
| beat | output | 2 | Beats advanced since the last load, modulo 4 |

## Verification
The hardest cases to reach from the ports are the wrap on the fifth advance and a load that arrives together with an advance. The stimulus table covers both. It runs complete four-advance bursts in each order and checks that the address comes back to its starting value. It puts an idle cycle in the middle of an interleaved burst to show that the burst holds. Its final rows pair strobes with a low `adv_n` and assert both strobes at once. A directed step then applies reset in the middle of a burst, with a beat count that is not zero.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strb_a_n,
  input  logic              strb_b_n,
  input  logic              adv_n,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat
);
  localparam int LOW_W = 2;

  logic [ADDR_W-1:0] start_q;
  logic [LOW_W-1:0]  cnt_q;
  logic [LOW_W-1:0]  low;
  logic              load, step;

  assign load = ~strb_a_n | ~strb_b_n;
  assign step = ~adv_n & ~load;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      start_q <= addr_in;
      cnt_q   <= '0;
    end else if (step) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign low      = order_xor ? (start_q[LOW_W-1:0] ^ cnt_q)
                              : (start_q[LOW_W-1:0] + cnt_q);
  assign addr_out = {start_q[ADDR_W-1:LOW_W], low};
  assign beat     = cnt_q;
endmodule

module burst_addr_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              strb_a_n,
  input logic              strb_b_n,
  input logic              adv_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        beat
);
  // R2 / R3
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!strb_a_n || !strb_b_n) |=> (addr_out == $past(addr_in) && beat == 2'd0));

  // R6
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (strb_a_n && strb_b_n && !adv_n) |=> (beat == $past(beat) + 2'd1));

  // R7
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (strb_a_n && strb_b_n && adv_n) |=> $stable(beat));

  // R8
  p_prio_r8: assert property (@(posedge clk) disable iff (rst)
    ((!strb_a_n || !strb_b_n) && !adv_n) |=> (beat == 2'd0));

  // R9
  p_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (strb_a_n && strb_b_n) |=> $stable(addr_out[ADDR_W-1:2]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .strb_a_n(strb_a_n), .strb_b_n(strb_b_n),
  .adv_n(adv_n), .addr_in(addr_in), .addr_out(addr_out), .beat(beat)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;
  localparam int W = 8;
  localparam int NV = 17;
  // {sa_n, sb_n, adv_n, order, addr_in[7:0], exp_addr[7:0], exp_beat[1:0], req[3:0]}
  localparam logic [25:0] VEC [NV] = '{
    {4'b0110, 8'hA6, 8'hA6, 2'd0, 4'd2},  // R2 load, linear
    {4'b1100, 8'h00, 8'hA7, 2'd1, 4'd4},  // R4
    {4'b1100, 8'h00, 8'hA4, 2'd2, 4'd4},  // R4
    {4'b1100, 8'h00, 8'hA5, 2'd3, 4'd4},  // R4
    {4'b1100, 8'h00, 8'hA6, 2'd0, 4'd6},  // R6 wrap
    {4'b1110, 8'hFF, 8'hA6, 2'd0, 4'd7},  // R7 hold
    {4'b1011, 8'h35, 8'h35, 2'd0, 4'd3},  // R3 load, interleaved
    {4'b1101, 8'h00, 8'h34, 2'd1, 4'd5},  // R5
    {4'b1101, 8'h00, 8'h37, 2'd2, 4'd5},  // R5
    {4'b1111, 8'hAA, 8'h37, 2'd2, 4'd7},  // R7 mid-burst
    {4'b1101, 8'h00, 8'h36, 2'd3, 4'd9},  // R9 upper held
    {4'b1101, 8'h00, 8'h35, 2'd0, 4'd6},  // R6 wrap interleaved
    {4'b0101, 8'hC3, 8'hC3, 2'd0, 4'd8},  // R8 strobe beats advance
    {4'b1001, 8'h1E, 8'h1E, 2'd0, 4'd8},  // R8 second strobe
    {4'b0111, 8'h52, 8'h52, 2'd0, 4'd10}, // R10 back-to-back
    {4'b0010, 8'h99, 8'h99, 2'd0, 4'd3},  // R3 both strobes
    {4'b1100, 8'h00, 8'h9A, 2'd1, 4'd4}   // R4
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sa_n = 1'b1, sb_n = 1'b1, adv_n = 1'b1, order = 1'b0;
  logic [W-1:0] addr_in = '0;
  logic [W-1:0] addr_out;
  logic [1:0]   beat;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(W)) dut_i (
    .clk(clk), .rst(rst), .strb_a_n(sa_n), .strb_b_n(sb_n), .adv_n(adv_n),
    .order_xor(order), .addr_in(addr_in), .addr_out(addr_out), .beat(beat)
  );

  task automatic check(input int req, input logic [W-1:0] ea, input logic [1:0] eb);
    checks++;
    if (addr_out !== ea || beat !== eb) begin
      fails++;
      $display("FAIL R%0d: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, addr_out, beat, ea, eb);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(1, 8'h00, 2'd0);  // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      {sa_n, sb_n, adv_n, order} = VEC[i][25:22];
      addr_in = VEC[i][21:14];
      @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i][3:0]), VEC[i][13:6], VEC[i][5:4]);
    end
    // R1: reset mid-burst with nonzero beat
    {sa_n, sb_n, adv_n} = 3'b111;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(1, 8'h00, 2'd0);
    // R7: idle after reset keeps zero
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(7, 8'h00, 2'd0);
    // R5 / R6: interleaved full wrap from start 2'b11
    order = 1'b1; sa_n = 1'b0; addr_in = 8'h4B;
    @(posedge clk); @(negedge clk);
    check(5, 8'h4B, 2'd0);
    sa_n = 1'b1; adv_n = 1'b0;
    @(posedge clk); @(negedge clk); check(5, 8'h4A, 2'd1);
    @(posedge clk); @(negedge clk); check(5, 8'h49, 2'd2);
    @(posedge clk); @(negedge clk); check(5, 8'h48, 2'd3);
    @(posedge clk); @(negedge clk); check(6, 8'h4B, 2'd0);
    adv_n = 1'b1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule